// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns one reference clock into a square-wave clock at sixteen times a chosen serial bit rate, for a UART's transmit and receive sections. Everything runs on one system clock. The reference comes in as a one-cycle pulse per reference period. That pulse is either the oscillator-enable input or a rising edge found on a sampled external clock level, and a source-select pin picks between them. The divide ratios assume a 2.4576 MHz reference, so code 1000 gives 153.6 kHz, which is 16 times 9600 baud.

A 4-bit rate code chooses one of fourteen divided outputs, thirteen of them distinct rates. Two codes pass an auxiliary input straight to the output instead. That input can carry another clock, or a fixed level that stops the line. A three-stage divide-by-8 tap chain and the reference pulse itself are brought out so that more channels can share the same source. A new rate code is taken only when the current output period ends, so the output never shows a shortened pulse. The 1800-baud ratio is not a whole number, so it is made from a repeating run of three periods.

When the external clock source is chosen, the divider chain is cleared once on the first high level of the external clock. A high level on the external clock while the oscillator source is chosen holds the chain in clear.

Top module: `baud_gen`

## Requirements
- R1: A synchronous active-high `rst` clears all tap stages and the period counter. At the clock edge after `rst` is sampled high, `z` and `tap` are 0.
- R2: `tap` is a 3-bit binary count of the reference pulses consumed since the last clear, with bit 0 the fastest. It changes only on a consumed reference pulse, so `tap[2]` has a period of 8 reference cycles.
- R3: `ref_out` equals `osc_tick` while `src_sel` is 1. While `src_sel` is 0, `ref_out` is high for one clock, two clocks after `ext_clk` goes from 0 to 1, and only then.
- R4: For rate codes 2 to 15 other than 10, `z` has a period of N reference pulses, where N is 3072, 2048, 1142, 768, 256, 64, 16, 32, (code 10), 128, 64, 512, 1024, 1396 for codes 2 through 15. `z` is low for N/2 pulses and high for N/2, so the duty cycle is 50%.
- R5: Rate code 10 (1800 baud) repeats the periods 85, 85, 86, for 256 reference pulses over three periods. Each period is low for floor(N/2) pulses.
- R6: Rate codes 0 and 1 route `aux_in` to `z` through one register stage. The divided count has no effect on `z` in those codes.
- R7: A rate code change takes effect only at the end of the period in progress. That period finishes with its old length, and the next period uses the new code.
- R8: After `src_sel` goes from 1 to 0, the first high level of `ext_clk` clears the tap chain and the period counter once. Later `ext_clk` edges count as reference pulses and do not clear the chain again.
- R9: While `src_sel` is 1 and `ext_clk` is high, the chain is held in clear: `tap` stays 0 and `z` stays low even though oscillator pulses arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | 1 selects the oscillator enable, 0 selects the external clock |
| osc_tick | input | 1 | Oscillator reference pulse, one clock wide |
| ext_clk | input | 1 | External reference clock level |
| rate_sel | input | 4 | Rate code |
| aux_in | input | 1 | Auxiliary input routed to z by codes 0 and 1 |
| ref_out | output | 1 | Reference pulse in use |
| tap | output | 3 | Divide-by-8 tap chain stage outputs |
| z | output | 1 | 16x bit-rate clock |

## Verification
Two events can land on the same clock edge. A rate code can change on the very reference pulse that ends a period, and a clear from the external clock can arrive on the same edge as the reference pulse made by that clock's rising edge. The first case is provoked by changing the code just after an output rising edge. The bench then judges it by checking that the period in progress still ends with its old length in reference pulses and that the next period has the new length. The second case is forced by switching to the external source with the tap chain at a nonzero count. The clear must win, which leaves `tap` at 0, and the next external edge must move it to 1.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
   localparam int          CODE_W    = 4;
   localparam int          RATIO_MAX = 3072;
   localparam int          CNT_W     = $clog2(RATIO_MAX + 1);
   localparam int          FRAC_LEN  = 3;
   localparam logic [3:0]  CODE_FRAC = 4'd10;

   typedef logic [CNT_W-1:0] ratio_t;

   // codes 0 and 1 route the auxiliary input
   function automatic logic is_pass(input logic [CODE_W-1:0] c);
      return (c[CODE_W-1:1] == '0);
   endfunction

   // reference pulses per output period; last_ph picks the long 1800 period
   function automatic ratio_t ratio_of(input logic [CODE_W-1:0] c, input logic last_ph);
      ratio_t r;
      case (c)
         4'd2:    r = ratio_t'(3072);
         4'd3:    r = ratio_t'(2048);
         4'd4:    r = ratio_t'(1142);
         4'd5:    r = ratio_t'(768);
         4'd6:    r = ratio_t'(256);
         4'd7:    r = ratio_t'(64);
         4'd8:    r = ratio_t'(16);
         4'd9:    r = ratio_t'(32);
         4'd10:   r = last_ph ? ratio_t'(86) : ratio_t'(85);
         4'd11:   r = ratio_t'(128);
         4'd12:   r = ratio_t'(64);
         4'd13:   r = ratio_t'(512);
         4'd14:   r = ratio_t'(1024);
         4'd15:   r = ratio_t'(1396);
         default: r = ratio_t'(2);
      endcase
      return r;
   endfunction
endpackage

// File: rtl/baud_gen_src.sv
module baud_gen_src (
   input  logic clk,
   input  logic rst,
   input  logic src_sel,
   input  logic osc_tick,
   input  logic ext_clk,
   output logic ref_tick,
   output logic init_clr
);
   logic ext_q, ext_q2, armed_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         ext_q   <= 1'b0;
         ext_q2  <= 1'b0;
         armed_q <= 1'b1;
      end else begin
         ext_q  <= ext_clk;
         ext_q2 <= ext_q;
         if (src_sel)
            armed_q <= 1'b1;
         else if (ext_q)
            armed_q <= 1'b0;
      end
   end

   // continuous hold in oscillator mode, one-shot when entering external mode
   assign init_clr = ext_q & (src_sel | armed_q);
   assign ref_tick = src_sel ? osc_tick : (ext_q & ~ext_q2);
endmodule

// File: rtl/baud_gen_taps.sv
module baud_gen_taps #(
   parameter int TAP_N = 3
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             tick,
   output logic [TAP_N-1:0] tap
);
   logic [TAP_N:0] carry;
   assign carry[0] = tick;

   for (genvar i = 0; i < TAP_N; i++) begin : g_stage
      logic st_q;
      always_ff @(posedge clk) begin
         if (clr)
            st_q <= 1'b0;
         else if (carry[i])
            st_q <= ~st_q;
      end
      assign carry[i+1] = carry[i] & st_q;
      assign tap[i]     = st_q;
   end
endmodule

// File: rtl/baud_gen_div.sv
module baud_gen_div
   import baud_gen_pkg::*;
#(
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              clr,
   input  logic              tick,
   input  logic [CODE_W-1:0] code,
   input  logic              aux_in,
   output logic              z,
   output logic              aux_act
);
   logic [CODE_W-1:0] act_q;
   ratio_t            cnt_q;
   ratio_t            n_cur;
   logic              aux_q;
   logic              ph_last;
   logic              wrap;

   assign aux_act = is_pass(act_q);
   assign n_cur   = ratio_of(act_q, ph_last);
   assign wrap    = tick & (aux_act | (cnt_q == n_cur - 1'b1));

   always_ff @(posedge clk) begin
      if (clr) begin
         cnt_q <= '0;
         act_q <= code;
         aux_q <= 1'b0;
      end else begin
         aux_q <= aux_in;
         if (wrap) begin
            cnt_q <= '0;
            act_q <= code;
         end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   if (FRAC_EN) begin : g_frac
      logic [1:0] ph_q;
      always_ff @(posedge clk) begin
         if (clr)
            ph_q <= '0;
         else if (wrap)
            ph_q <= (act_q == CODE_FRAC && ph_q != 2'(FRAC_LEN - 1)) ? ph_q + 1'b1 : 2'd0;
      end
      assign ph_last = (ph_q == 2'(FRAC_LEN - 1));
   end else begin : g_nofrac
      assign ph_last = 1'b0;
   end

   assign z = aux_act ? aux_q : (cnt_q >= (n_cur >> 1));
endmodule

// File: rtl/baud_gen.sv
module baud_gen
   import baud_gen_pkg::*;
#(
   parameter int TAP_N   = 3,
   parameter bit FRAC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              src_sel,
   input  logic              osc_tick,
   input  logic              ext_clk,
   input  logic [CODE_W-1:0] rate_sel,
   input  logic              aux_in,
   output logic              ref_out,
   output logic [TAP_N-1:0]  tap,
   output logic              z
);
   if (TAP_N < 1 || TAP_N > 8) begin : g_bad_taps
      $error("baud_gen: TAP_N out of range");
   end
   if (CNT_W < $clog2(RATIO_MAX + 1)) begin : g_bad_cnt
      $error("baud_gen: counter too narrow");
   end

   logic ref_tick;
   logic init_clr;
   logic chain_clr;
   logic aux_act;

   baud_gen_src u_src (
      .clk      (clk),
      .rst      (rst),
      .src_sel  (src_sel),
      .osc_tick (osc_tick),
      .ext_clk  (ext_clk),
      .ref_tick (ref_tick),
      .init_clr (init_clr)
   );

   assign chain_clr = rst | init_clr;
   assign ref_out   = ref_tick;

   baud_gen_taps #(.TAP_N(TAP_N)) u_taps (
      .clk  (clk),
      .clr  (chain_clr),
      .tick (ref_tick),
      .tap  (tap)
   );

   baud_gen_div #(.FRAC_EN(FRAC_EN)) u_div (
      .clk     (clk),
      .clr     (chain_clr),
      .tick    (ref_tick),
      .code    (rate_sel),
      .aux_in  (aux_in),
      .z       (z),
      .aux_act (aux_act)
   );
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
   parameter int TAP_N = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             chain_clr,
   input logic             aux_act,
   input logic             ref_out,
   input logic [TAP_N-1:0] tap,
   input logic             z
);
   assert_rst_clear_R1: assert property (@(posedge clk)
      rst |=> (!z && tap == '0));

   assert_tap_step_R2: assert property (@(posedge clk) disable iff (rst)
      (ref_out && !chain_clr) |=> (tap == TAP_N'($past(tap) + 1'b1)));

   assert_tap_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!ref_out && !chain_clr) |=> $stable(tap));

   // R4: a divided output moves only on a reference pulse or a clear
   assert_z_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
      !$stable(z) |-> $past(ref_out || chain_clr || aux_act));

   assert_chain_clear_R8: assert property (@(posedge clk) disable iff (rst)
      chain_clr |=> (tap == '0 && !z));
endmodule

bind baud_gen baud_gen_chk #(.TAP_N(TAP_N)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .chain_clr (chain_clr),
   .aux_act   (aux_act),
   .ref_out   (ref_out),
   .tap       (tap),
   .z         (z)
);

// File: tb/baud_gen_bench.sv
module baud_gen_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       src_sel = 1'b1;
   logic       osc_tick = 1'b0;
   logic       ext_clk = 1'b0;
   logic [3:0] rate_sel = 4'd8;
   logic       aux_in = 1'b0;
   logic       ref_out;
   logic [2:0] tap;
   logic       z;

   int  compared = 0, mismatched = 0;
   bit  run_ticks = 1'b0, done = 1'b0;
   int  tick_cnt = 0, fall_at = 0, rise_at = 0, last_period = 0, hi_len = 0;
   int  n_fall = 0, n_rise = 0;
   logic z_prev = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   baud_gen u_baud_gen (
      .clk(clk), .rst(rst), .src_sel(src_sel), .osc_tick(osc_tick),
      .ext_clk(ext_clk), .rate_sel(rate_sel), .aux_in(aux_in),
      .ref_out(ref_out), .tap(tap), .z(z)
   );

   // oscillator pulses: random density about 3 in 4
   initial forever begin
      @(posedge clk); #1;
      osc_tick = run_ticks && ($urandom % 4 != 0);
   end

   // period monitor, in reference pulses
   always @(negedge clk) begin
      if (z_prev && !z) begin
         last_period = tick_cnt - fall_at;
         hi_len      = tick_cnt - rise_at;
         fall_at     = tick_cnt;
         n_fall++;
      end
      if (!z_prev && z) begin
         rise_at = tick_cnt;
         n_rise++;
      end
      z_prev = z;
      if (ref_out) tick_cnt++;
   end

   task automatic check(input string req, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic wait_fall();
      int f = n_fall;
      while (n_fall == f) begin
         @(posedge clk); #2;
      end
   endtask

   task automatic wait_rise();
      int r = n_rise;
      while (n_rise == r) begin
         @(posedge clk); #2;
      end
   endtask

   function automatic int exp_ratio(input int c);
      case (c)
         2: return 3072;  3: return 2048;  4: return 1142;  5: return 768;
         6: return 256;   7: return 64;    8: return 16;    9: return 32;
         10: return 85;   11: return 128;  12: return 64;   13: return 512;
         14: return 1024; default: return 1396;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int base, b0, t0;
      int order[13] = '{2, 3, 4, 5, 6, 7, 8, 9, 11, 12, 13, 14, 15};
      void'($urandom(32'd4702));
      cyc(2);
      // R1: reset state
      check("R1 z after reset", int'(z), 0);
      check("R1 tap after reset", int'(tap), 0);
      rst = 1'b0;
      base = tick_cnt;
      run_ticks = 1'b1;

      // R3 and R2: oscillator pulse routing and tap count
      for (int k = 0; k < 6; k++) begin
         cyc(1 + $urandom % 7);
         check("R3 ref_out follows osc_tick", int'(ref_out), int'(osc_tick));
         check("R2 tap count", int'(tap), (tick_cnt - base) % 8);
      end

      // R4: every whole ratio, random order
      for (int i = 12; i > 0; i--) begin
         int j = $urandom % (i + 1);
         int t = order[i];
         order[i] = order[j];
         order[j] = t;
      end
      foreach (order[k]) begin
         rate_sel = 4'(order[k]);
         wait_fall();
         wait_fall();
         check($sformatf("R4 period code %0d", order[k]), last_period, exp_ratio(order[k]));
         check($sformatf("R4 high time code %0d", order[k]), hi_len, exp_ratio(order[k]) / 2);
      end

      // R5: 1800 baud sequence
      rate_sel = 4'd10;
      wait_fall();
      wait_fall();
      check("R5 first period", last_period, 85);
      wait_fall();
      check("R5 second period", last_period, 85);
      check("R5 second low time", last_period - hi_len, 42);
      wait_fall();
      check("R5 third period", last_period, 86);
      check("R5 third low time", last_period - hi_len, 43);

      // R7: code change mid-period
      rate_sel = 4'd8;
      wait_fall();
      wait_fall();
      wait_rise();
      rate_sel = 4'd9;
      wait_fall();
      check("R7 period in progress keeps old ratio", last_period, 16);
      wait_fall();
      check("R7 next period uses new ratio", last_period, 32);

      // R6: auxiliary pass-through
      rate_sel = 4'd1;
      wait_fall();
      for (int k = 0; k < 24; k++) begin
         logic v = 1'($urandom % 2);
         aux_in = v;
         @(posedge clk); #2;
         check("R6 z follows aux_in", int'(z), int'(v));
      end
      aux_in = 1'b0;
      rate_sel = 4'd8;
      wait_fall();
      wait_fall();
      check("R6 leaving pass-through", last_period, 16);

      // R1: reset mid-run
      rst = 1'b1;
      cyc(1);
      check("R1 z after mid-run reset", int'(z), 0);
      check("R1 tap after mid-run reset", int'(tap), 0);
      rst = 1'b0;
      cyc(1);

      // R8: external clock entry clears once
      while (tap == 3'd0) cyc(1);
      run_ticks = 1'b0;
      cyc(3);
      t0 = int'(tap);
      src_sel = 1'b0;
      cyc(4);
      check("R8 no change before ext high", int'(tap), t0);
      ext_clk = 1'b1;
      cyc(4);
      check("R8 first ext high clears chain", int'(tap), 0);
      ext_clk = 1'b0;
      cyc(3);
      ext_clk = 1'b1;
      cyc(3);
      check("R8 R3 later ext edge counts", int'(tap), 1);
      ext_clk = 1'b0;
      cyc(3);

      // R9: oscillator mode with ext_clk high holds clear
      src_sel = 1'b1;
      run_ticks = 1'b1;
      cyc(5);
      ext_clk = 1'b1;
      cyc(20);
      check("R9 tap held", int'(tap), 0);
      check("R9 z held low", int'(z), 0);
      ext_clk = 1'b0;
      cyc(3);
      b0 = int'(tap);
      base = tick_cnt;
      cyc(17);
      check("R9 R2 counting resumes", int'(tap), (b0 + tick_cnt - base) % 8);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule